// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for the indexed addressing forms of an 8-bit processor with 16-bit pointer registers. The decoder presents a mode code, the value of the selected base register, the two accumulators, a constant displacement, an indirection flag and a flag marking a load-effective-address operation. It then pulses `start`. The block returns the final address, the value to write back to the base register with its enable, and a zero-flag result for load-effective-address operations. All of these are valid in the cycle `done` is high.

The base register may be one of the index registers, one of the stack pointers, or the program counter. When indirection is requested, the address that was computed points at a stored 16-bit pointer. The block fetches that pointer one byte at a time over a synchronous read port with a valid/ready request and a one-cycle response strobe. The fetched pointer then becomes the result. Auto-increment and auto-decrement write-back still applies to the base register when indirection is used.

Top module: `idx_ea_gen`

## Requirements
- R1: Without indirection, and with all arithmetic modulo 2^16, the address is base plus an offset with no write-back. The offset depends on the mode code: 0 uses no offset, 8 uses the sign-extended low byte of `disp`, and 9 uses all 16 bits of `disp`. The reserved codes 12 to 15 behave like code 0.
- R2: Code 5 adds the sign-extended `acc_a` and code 6 adds the sign-extended `acc_b`. Code 7 adds the 16-bit pair formed with `acc_a` as the high byte and `acc_b` as the low byte. None of these modes writes back.
- R3: Codes 1 and 2 (post-increment) give the unchanged base as the address. The write-back value is base+1 for code 1 and base+2 for code 2, with `base_we` high.
- R4: Codes 3 and 4 (pre-decrement) give base-1 for code 3 and base-2 for code 4. That value is both the address and the write-back value, with `base_we` high.
- R5: Codes 10 and 11 (program-counter relative) add the sign-extended 8-bit or the full 16-bit `disp` to the base input, which carries the program counter. Neither code writes back.
- R6: A direct request (`indirect` low) accepted at a clock edge raises `done` for the following cycle. `base_we` is never high unless `done` is high.
- R7: With `indirect` high, the block reads the byte at the computed address as the high byte and the byte at the next address (wrapping) as the low byte. It issues exactly two read requests. The final address is {high, low}. The write-back value and enable are the same as they would be without indirection.
- R8: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request and its address hold steady. Only one read is outstanding at a time, and `mem_rd_valid` is high only while `busy` is high.
- R9: A `start` while `busy` is high is ignored. It produces no extra `done` and does not alter the result in flight.
- R10: When `lea` is set on the accepted request, `zf_we` is high together with `done`, and `zf` is 1 exactly when the final address is zero. `zf_we` is never high without `done`.
- R11: After reset, `done`, `busy`, `mem_rd_valid`, `base_we` and `zf_we` are low and `ea` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, accepted when `busy` is low |
| mode | input | 4 | Addressing mode code |
| indirect | input | 1 | Fetch a stored pointer at the computed address |
| lea | input | 1 | Request is a load-effective-address operation |
| base | input | 16 | Base register value (index, stack or program counter) |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| disp | input | 16 | Constant displacement (low byte used in 8-bit modes) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 16 | Read request byte address |
| mem_rd_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Results valid this cycle |
| ea | output | 16 | Final effective address |
| base_new | output | 16 | Value for base register write-back |
| base_we | output | 1 | Base register write-back enable |
| zf_we | output | 1 | Zero flag update enable |
| zf | output | 1 | Zero flag value |

## Verification
Two things can land in the same cycle. One is the completion pulse of one request; the other is the acceptance of the next `start`, which is presented while that `done` is high. The bench provokes this twice. It holds `start` across the completion cycle of a direct request, with new operands already applied, and it issues a direct request in the cycle an indirect fetch completes. It judges each result against its own request's expected address and write-back, so a stale or mixed result is caught. It also drives `start` repeatedly during a pointer fetch and checks that only one completion arrives, carrying the first request's values.

// File: rtl/idx_ea_pkg.sv
// Shared types of the indexed effective address generator.
// Assumes: mode codes are fixed by the instruction decoder.
package idx_ea_pkg;

    typedef enum logic [3:0] {
        AM_ZERO   = 4'd0,
        AM_POST1  = 4'd1,
        AM_POST2  = 4'd2,
        AM_PRE1   = 4'd3,
        AM_PRE2   = 4'd4,
        AM_ACC_A  = 4'd5,
        AM_ACC_B  = 4'd6,
        AM_ACC_D  = 4'd7,
        AM_DISP8  = 4'd8,
        AM_DISP16 = 4'd9,
        AM_PCR8   = 4'd10,
        AM_PCR16  = 4'd11
    } am_e;

    typedef enum logic [2:0] {
        FS_IDLE    = 3'd0,
        FS_HI_REQ  = 3'd1,
        FS_HI_WAIT = 3'd2,
        FS_LO_REQ  = 3'd3,
        FS_LO_WAIT = 3'd4
    } fs_e;

endpackage

// File: rtl/idx_ea_offset.sv
// Offset selector: picks and widens the value added to the base register.
// Assumes: AW == 2*DW, so the accumulator pair exactly fills an address.
module idx_ea_offset
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [3:0]    mode,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] off
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] sx_a;
    logic [AW-1:0] sx_b;
    logic [AW-1:0] sx_d8;
    logic [AW-1:0] pair;

    // Sign-extend the byte-wide sources and form the accumulator pair.
    always_comb begin
        sx_a  = {{EXT{acc_a[DW-1]}}, acc_a};
        sx_b  = {{EXT{acc_b[DW-1]}}, acc_b};
        sx_d8 = {{EXT{disp[DW-1]}}, disp[DW-1:0]};
        pair  = AW'({acc_a, acc_b});
    end

    // Choose the offset for the requested mode.
    always_comb begin
        case (am_e'(mode))
            AM_ACC_A:  off = sx_a;
            AM_ACC_B:  off = sx_b;
            AM_ACC_D:  off = pair;
            AM_DISP8:  off = sx_d8;
            AM_PCR8:   off = sx_d8;
            AM_DISP16: off = disp;
            AM_PCR16:  off = disp;
            default:   off = '0;
        endcase
    end

endmodule

// File: rtl/idx_ea_calc.sv
// Address arithmetic: offset sum, auto-increment and auto-decrement.
// Assumes: all sums wrap modulo 2^AW; write-back only for stepping modes.
module idx_ea_calc
    import idx_ea_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off,
    output logic [AW-1:0] ea_raw,
    output logic [AW-1:0] base_upd,
    output logic          wb_en
);
    localparam logic [AW-1:0] STEP1 = AW'(1);
    localparam logic [AW-1:0] STEP2 = AW'(2);

    logic [AW-1:0] step;
    logic [AW-1:0] inc;
    logic [AW-1:0] dec;
    logic [AW-1:0] sum;

    // Step size for the stepping modes.
    always_comb begin
        case (am_e'(mode))
            AM_POST2, AM_PRE2: step = STEP2;
            default:           step = STEP1;
        endcase
    end

    // The three candidate results.
    always_comb begin
        inc = base + step;
        dec = base - step;
        sum = base + off;
    end

    // Select address and write-back by mode.
    always_comb begin
        case (am_e'(mode))
            AM_POST1, AM_POST2: begin
                ea_raw   = base;
                base_upd = inc;
                wb_en    = 1'b1;
            end
            AM_PRE1, AM_PRE2: begin
                ea_raw   = dec;
                base_upd = dec;
                wb_en    = 1'b1;
            end
            default: begin
                ea_raw   = sum;
                base_upd = base;
                wb_en    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idx_ea_ptr_fetch.sv
// Pointer fetch: reads a two-byte pointer, high byte at the lower address.
// Assumes: the memory answers each accepted request with exactly one
// response strobe, at least one cycle after acceptance.
module idx_ea_ptr_fetch
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] ptr_addr,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          fin,
    output logic [AW-1:0] value,
    output logic          busy
);
    fs_e           state;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] hi_q;

    // Sequence the two byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            addr_q <= '0;
            hi_q   <= '0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (go) begin
                        addr_q <= ptr_addr;
                        state  <= FS_HI_REQ;
                    end
                end
                FS_HI_REQ: begin
                    if (rd_ready) state <= FS_HI_WAIT;
                end
                FS_HI_WAIT: begin
                    if (rsp_valid) begin
                        hi_q   <= rsp_data;
                        addr_q <= addr_q + AW'(1);
                        state  <= FS_LO_REQ;
                    end
                end
                FS_LO_REQ: begin
                    if (rd_ready) state <= FS_LO_WAIT;
                end
                FS_LO_WAIT: begin
                    if (rsp_valid) state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Request and completion outputs.
    always_comb begin
        rd_valid = (state == FS_HI_REQ) || (state == FS_LO_REQ);
        rd_addr  = addr_q;
        fin      = (state == FS_LO_WAIT) && rsp_valid;
        value    = AW'({hi_q, rsp_data});
        busy     = (state != FS_IDLE);
    end

endmodule

// File: rtl/idx_ea_gen.sv
// Top of the indexed effective address generator.
// Computes the address and base write-back for one request, optionally
// replacing the address by a pointer fetched from memory.
// Assumes: request inputs are valid in the cycle start is high; results
// are valid only while done is high.
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic          indirect,
    input  logic          lea,
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] acc_a,
    input  logic [DW-1:0] acc_b,
    input  logic [AW-1:0] disp,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] base_new,
    output logic          base_we,
    output logic          zf_we,
    output logic          zf
);
    logic [AW-1:0] off;
    logic [AW-1:0] ea_raw;
    logic [AW-1:0] base_upd;
    logic          wb_en;
    logic          fetch_busy;
    logic          fetch_fin;
    logic [AW-1:0] fetch_val;
    logic          accept;
    logic          done_q;
    logic [AW-1:0] ea_q;
    logic [AW-1:0] base_new_q;
    logic          wb_q;
    logic          lea_q;

    idx_ea_offset #(.AW(AW), .DW(DW)) u_off (
        .mode  (mode),
        .acc_a (acc_a),
        .acc_b (acc_b),
        .disp  (disp),
        .off   (off)
    );

    idx_ea_calc #(.AW(AW)) u_calc (
        .mode     (mode),
        .base     (base),
        .off      (off),
        .ea_raw   (ea_raw),
        .base_upd (base_upd),
        .wb_en    (wb_en)
    );

    // A request is taken only while no pointer fetch is running.
    always_comb accept = start && !fetch_busy;

    idx_ea_ptr_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (accept && indirect),
        .ptr_addr  (ea_raw),
        .rd_valid  (mem_rd_valid),
        .rd_addr   (mem_rd_addr),
        .rd_ready  (mem_rd_ready),
        .rsp_valid (mem_rsp_valid),
        .rsp_data  (mem_rsp_data),
        .fin       (fetch_fin),
        .value     (fetch_val),
        .busy      (fetch_busy)
    );

    // Capture request results and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            ea_q       <= '0;
            base_new_q <= '0;
            wb_q       <= 1'b0;
            lea_q      <= 1'b0;
        end else begin
            done_q <= (accept && !indirect) || fetch_fin;
            if (accept) begin
                base_new_q <= base_upd;
                wb_q       <= wb_en;
                lea_q      <= lea;
                if (!indirect) ea_q <= ea_raw;
            end
            if (fetch_fin) ea_q <= fetch_val;
        end
    end

    // Qualified outputs.
    always_comb begin
        busy     = fetch_busy;
        done     = done_q;
        ea       = ea_q;
        base_new = base_new_q;
        base_we  = done_q && wb_q;
        zf_we    = done_q && lea_q;
        zf       = (ea_q == '0);
    end

endmodule

// File: rtl/idx_ea_chk.sv
// Assertion checker for idx_ea_gen, attached by bind.
// Assumes: only port-level signals of the top are observed.
module idx_ea_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          indirect,
    input logic [3:0]    mode,
    input logic [AW-1:0] base,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic [AW-1:0] base_new,
    input logic          base_we,
    input logic          zf_we,
    input logic          mem_rd_valid,
    input logic          mem_rd_ready,
    input logic [AW-1:0] mem_rd_addr
);
    logic          hs_odd;
    logic [AW-1:0] first_addr;

    // Track which of the two pointer reads is being accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_odd     <= 1'b0;
            first_addr <= '0;
        end else if (mem_rd_valid && mem_rd_ready) begin
            hs_odd <= !hs_odd;
            if (!hs_odd) first_addr <= mem_rd_addr;
        end
    end

    // R6
    direct_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !indirect) |=> done);

    // R6
    wb_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> done);

    // R10
    zf_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zf_we |-> done);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R8
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> busy);

    // R3
    post1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !indirect && mode == 4'd1)
        |=> (ea == $past(base) && base_new == $past(base) + AW'(1) && base_we));

    // R4
    pre2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !indirect && mode == 4'd4)
        |=> (ea == $past(base) - AW'(2) && base_new == ea && base_we));

    // R7
    lo_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready && hs_odd) |-> (mem_rd_addr == first_addr + AW'(1)));

endmodule

bind idx_ea_gen idx_ea_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .indirect     (indirect),
    .mode         (mode),
    .base         (base),
    .done         (done),
    .ea           (ea),
    .base_new     (base_new),
    .base_we      (base_we),
    .zf_we        (zf_we),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_addr  (mem_rd_addr)
);

// File: tb/sim_idx_ea_gen.sv
module sim_idx_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic        indirect = 1'b0;
    logic        lea = 1'b0;
    logic [15:0] base = '0;
    logic [7:0]  acc_a = '0;
    logic [7:0]  acc_b = '0;
    logic [15:0] disp = '0;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_data = '0;
    logic        busy, done, base_we, zf_we, zf;
    logic [15:0] ea, base_new;

    int checks = 0;
    int errors = 0;
    int hs_total = 0;
    bit wd_hit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_ea_gen u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .indirect(indirect), .lea(lea), .base(base), .acc_a(acc_a),
        .acc_b(acc_b), .disp(disp), .mem_rd_valid(mem_rd_valid),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .ea(ea), .base_new(base_new),
        .base_we(base_we), .zf_we(zf_we), .zf(zf)
    );

    // Memory contents as a function of the address.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // Expected address, write-back value and enable from the requirements.
    function automatic void model(input logic [3:0] m, input logic [15:0] b,
                                  input logic [7:0] aa, input logic [7:0] bb,
                                  input logic [15:0] d, output logic [15:0] ea_r,
                                  output logic [15:0] nb, output logic we);
        logic [15:0] o;
        case (m)
            4'd5:        o = {{8{aa[7]}}, aa};
            4'd6:        o = {{8{bb[7]}}, bb};
            4'd7:        o = {aa, bb};
            4'd8, 4'd10: o = {{8{d[7]}}, d[7:0]};
            4'd9, 4'd11: o = d;
            default:     o = 16'h0000;
        endcase
        we = 1'b1;
        case (m)
            4'd1: begin ea_r = b; nb = b + 16'd1; end
            4'd2: begin ea_r = b; nb = b + 16'd2; end
            4'd3: begin nb = b - 16'd1; ea_r = nb; end
            4'd4: begin nb = b - 16'd2; ea_r = nb; end
            default: begin ea_r = b + o; nb = b; we = 1'b0; end
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd1, 4'd2:   return "R3";
            4'd3, 4'd4:   return "R4";
            4'd5, 4'd6, 4'd7: return "R2";
            4'd10, 4'd11: return "R5";
            default:      return "R1";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder: random ready, response 1 to 3 cycles after acceptance.
    initial begin
        int pend_cnt;
        logic [15:0] pend_addr;
        bit r;
        pend_cnt = 0;
        pend_addr = '0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend_cnt != 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = mem_byte(pend_addr);
                end
            end
            r = ($urandom % 3) != 0;
            mem_rd_ready = r;
            if (mem_rd_valid && r) begin
                pend_addr = mem_rd_addr;
                pend_cnt = 1 + int'($urandom % 3);
                hs_total++;
            end
        end
    end

    task automatic apply(input logic [3:0] m, input logic [15:0] b, input logic [7:0] aa,
                         input logic [7:0] bb, input logic [15:0] d, input bit ind, input bit lz);
        mode = m; base = b; acc_a = aa; acc_b = bb; disp = d; indirect = ind; lea = lz;
    endtask

    // Compare the outputs seen with done high against one request.
    task automatic judge(input logic [3:0] m, input logic [15:0] b, input logic [7:0] aa,
                         input logic [7:0] bb, input logic [15:0] d, input bit ind, input bit lz);
        logic [15:0] er, enb, fe;
        logic ew;
        string rq;
        model(m, b, aa, bb, d, er, enb, ew);
        fe = ind ? {mem_byte(er), mem_byte(er + 16'd1)} : er;
        rq = ind ? "R7" : req_of(m);
        check(done === 1'b1, "R6", "done", 32'(done), 32'd1);
        check(ea === fe, rq, "ea", 32'(ea), 32'(fe));
        check(base_we === ew, rq, "base_we", 32'(base_we), 32'(ew));
        if (ew) check(base_new === enb, rq, "base_new", 32'(base_new), 32'(enb));
        check(zf_we === lz, "R10", "zf_we", 32'(zf_we), 32'(lz));
        if (lz) check(zf === (fe == 16'h0), "R10", "zf", 32'(zf), 32'(fe == 16'h0));
    endtask

    // One complete request with its checks.
    task automatic run_op(input logic [3:0] m, input logic [15:0] b, input logic [7:0] aa,
                          input logic [7:0] bb, input logic [15:0] d, input bit ind, input bit lz);
        int lat, hs0;
        while (busy) @(negedge clk);
        hs0 = hs_total;
        apply(m, b, aa, bb, d, ind, lz);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        judge(m, b, aa, bb, d, ind, lz);
        if (!ind) check(lat == 1, "R6", "direct latency", 32'(lat), 32'd1);
        else check(hs_total - hs0 == 2, "R7", "read count", 32'(hs_total - hs0), 32'd2);
        @(negedge clk);
        check(done === 1'b0, "R6", "done pulse ends", 32'(done), 32'd0);
    endtask

    task automatic run_all();
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(done === 1'b0, "R11", "done", 32'(done), 32'd0);
        check(busy === 1'b0, "R11", "busy", 32'(busy), 32'd0);
        check(mem_rd_valid === 1'b0, "R11", "mem_rd_valid", 32'(mem_rd_valid), 32'd0);
        check(base_we === 1'b0, "R11", "base_we", 32'(base_we), 32'd0);
        check(zf_we === 1'b0, "R11", "zf_we", 32'(zf_we), 32'd0);
        check(ea === 16'h0, "R11", "ea", 32'(ea), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_op(4'd0, 16'h1234, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);   // R1
        run_op(4'd8, 16'h0010, 8'h00, 8'h00, 16'h0080, 1'b0, 1'b0);   // R1 negative byte
        run_op(4'd9, 16'hF000, 8'h00, 8'h00, 16'h2345, 1'b0, 1'b0);   // R1 wrap
        run_op(4'd13, 16'h4444, 8'h11, 8'h22, 16'h0101, 1'b0, 1'b0);  // R1 reserved
        run_op(4'd5, 16'h0100, 8'hFF, 8'h00, 16'h0000, 1'b0, 1'b0);   // R2
        run_op(4'd6, 16'h0100, 8'h00, 8'h7F, 16'h0000, 1'b0, 1'b0);   // R2
        run_op(4'd7, 16'h0001, 8'h80, 8'h02, 16'h0000, 1'b0, 1'b0);   // R2
        run_op(4'd1, 16'hFFFF, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);   // R3 wrap
        run_op(4'd2, 16'hFFFF, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);   // R3 wrap
        run_op(4'd3, 16'h0000, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);   // R4 wrap
        run_op(4'd4, 16'h0001, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0);   // R4 wrap
        run_op(4'd10, 16'h8000, 8'h00, 8'h00, 16'h00F6, 1'b0, 1'b0);  // R5
        run_op(4'd11, 16'h8000, 8'h00, 8'h00, 16'h9000, 1'b0, 1'b0);  // R5
        run_op(4'd9, 16'h1000, 8'h00, 8'h00, 16'hF000, 1'b0, 1'b1);   // R10 zero
        run_op(4'd9, 16'h1000, 8'h00, 8'h00, 16'h0001, 1'b0, 1'b1);   // R10 non-zero
        run_op(4'd9, 16'hFF00, 8'h00, 8'h00, 16'h00FF, 1'b1, 1'b0);   // R7 wrap of second byte
        run_op(4'd2, 16'h3000, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b1);   // R7 with write-back

        // R9: start pulses during a pointer fetch are ignored
        begin
            int waitn;
            apply(4'd8, 16'h2000, 8'h00, 8'h00, 16'h0004, 1'b1, 1'b0);
            start = 1'b1;
            @(negedge clk);
            apply(4'd1, 16'h5555, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1);
            check(busy === 1'b1, "R9", "busy after indirect start", 32'(busy), 32'd1);
            @(negedge clk);
            check(done === 1'b0, "R9", "no done for ignored start", 32'(done), 32'd0);
            start = 1'b0;
            waitn = 0;
            while (!done && waitn < 200) begin
                @(negedge clk);
                waitn++;
            end
            judge(4'd8, 16'h2000, 8'h00, 8'h00, 16'h0004, 1'b1, 1'b0);
            repeat (4) begin
                @(negedge clk);
                check(done === 1'b0, "R9", "no extra done", 32'(done), 32'd0);
            end
        end

        // R6: completion and next acceptance in the same cycle (direct)
        apply(4'd5, 16'h0200, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b0);
        start = 1'b1;
        @(negedge clk);
        judge(4'd5, 16'h0200, 8'h10, 8'h00, 16'h0000, 1'b0, 1'b0);
        apply(4'd3, 16'h0800, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1);
        @(negedge clk);
        judge(4'd3, 16'h0800, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b1);
        start = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R6", "done after back-to-back", 32'(done), 32'd0);

        // R7/R6: direct start in the cycle an indirect fetch completes
        begin
            int waitn;
            apply(4'd0, 16'h4321, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            waitn = 0;
            while (!done && waitn < 200) begin
                @(negedge clk);
                waitn++;
            end
            judge(4'd0, 16'h4321, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0);
            apply(4'd9, 16'h0003, 8'h00, 8'h00, 16'h0100, 1'b0, 1'b0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            judge(4'd9, 16'h0003, 8'h00, 8'h00, 16'h0100, 1'b0, 1'b0);
        end

        // Random mix
        for (n = 0; n < 300; n++) begin
            run_op(4'($urandom % 16), 16'($urandom), 8'($urandom), 8'($urandom),
                   16'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0);
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule